// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block switches a group of clock outputs on and off in response to an asynchronous, active-low stop request. The request is brought into the source clock domain through a flop chain. A small state machine then decides when the group may run. Each output's enable flop loads on the falling edge of the source clock and is ANDed with that clock. As a result, an output can only stop during a low phase and can only resume at the start of a full high phase.

Once the outputs restart, they must stay running for a minimum number of cycles. A stop request that arrives inside that window waits until the window has elapsed. A per-output mask, driven from configuration registers, can hold any gated output low at any time. A second set of outputs never sees the stop request and follows only its own mask.

The same block serves two clock groups:
- With two synchronizer stages and a 100-cycle window, it suits a processor clock group.
- With one stage and a 10-cycle window, it suits a peripheral bus group.

The state machine has three states:
- `ST_RUN`: running, free to stop.
- `ST_STOPPED`: outputs held low.
- `ST_HOLD`: running inside the minimum window.

It has five transitions:
- `ST_RUN`→`ST_STOPPED`: the synchronized request is active.
- `ST_STOPPED`→`ST_HOLD`: the request is released.
- `ST_HOLD`→`ST_HOLD`: the window counter is not yet zero.
- `ST_HOLD`→`ST_STOPPED`: the counter is zero and the request is active.
- `ST_HOLD`→`ST_RUN`: the counter is zero and the request is inactive.

Reset enters `ST_RUN`.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_ni is low, every output is low. After release, each output runs according to its mask from the first high phase that follows a falling edge.
- R2: While running, gated output i repeats clk_i when gate_mask_i bit i is 1 and stays low when it is 0. A mask change takes effect in the high phase after the next falling edge of clk_i.
- R3: Free output j repeats clk_i when free_mask_i bit j is 1 and stays low when it is 0, whatever stop_ni does.
- R4: Every output is low for the whole of each low phase of clk_i. Every high pulse is a full high phase.
- R5: If stop_ni is first sampled low at rising edge k while in ST_RUN, gated outputs still pulse in high phase k+SYNC_STAGES-1 and are low from high phase k+SYNC_STAGES. With the default of two stages, this is two cycles.
- R6: While stopped, all gated outputs stay low for any value of gate_mask_i.
- R7: If stop_ni is first sampled high at rising edge k while stopped, gated outputs are still low in high phase k+SYNC_STAGES-1. They give a full pulse in high phase k+SYNC_STAGES.
- R8: After a restart, gated outputs run for at least MIN_RUN consecutive high phases. A request that returns low inside that window takes effect exactly MIN_RUN phases after the first restored pulse. A request that stays high keeps the outputs running past the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock; also the reference clock for synchronization and the state machine |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request for the gated outputs |
| gate_mask_i | input | N_GATED | Per-output enable for gated outputs (1 = may run) |
| free_mask_i | input | N_FREE | Per-output enable for free outputs (1 = runs) |
| gated_clk_o | output | N_GATED | Clock outputs that obey the stop request and mask |
| free_clk_o | output | N_FREE | Clock outputs that obey only their mask |

## Verification
A mask change is due in the first high phase after the next falling edge. A change of stop_ni first sampled at rising edge k is due in high phase k+SYNC_STAGES. The bench drives every input 2 ns after a rising edge and samples 5 ns into the chosen phase. For each latency it checks both the last phase before the change and the phase of the change. The minimum window is measured by counting consecutive full pulses after a one-cycle release, then requiring exactly MIN_RUN of them followed by a low phase.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    // Run/stop control states of the gate sequencer
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,  // running, stop request honoured
        ST_STOPPED = 2'd1,  // gated outputs held low
        ST_HOLD    = 2'd2   // running inside minimum-enable window
    } gate_state_e;

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_ni,
    output logic stop_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q <= 1'b1;
                end else begin
                    chain_q <= req_ni;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], req_ni};
                end
            end
        end
    endgenerate

    // Active-high stop after the last stage
    assign stop_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/clk_stop_fsm.sv
module clk_stop_fsm
    import clk_stop_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    output logic run_o
);

    localparam int CNT_W = (MIN_RUN > 2) ? $clog2(MIN_RUN) : 1;
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(MIN_RUN - 1);

    gate_state_e      state_q, state_n;
    logic [CNT_W-1:0] win_q, win_n;

    // State register and window counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            win_q   <= '0;
        end else begin
            state_q <= state_n;
            win_q   <= win_n;
        end
    end

    // Transition logic
    always_comb begin
        state_n = state_q;
        win_n   = win_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_i) begin
                    state_n = ST_STOPPED;
                end
            end
            ST_STOPPED: begin
                if (!stop_i) begin
                    state_n = ST_HOLD;
                    win_n   = WIN_LOAD;
                end
            end
            ST_HOLD: begin
                if (win_q != '0) begin
                    win_n = win_q - 1'b1;
                end else if (stop_i) begin
                    state_n = ST_STOPPED;
                end else begin
                    state_n = ST_RUN;
                end
            end
            default: begin
                state_n = ST_STOPPED;
            end
        endcase
    end

    // Output decode: the negedge gate flops sample this mid-cycle
    always_comb begin
        run_o = (state_n != ST_STOPPED);
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic clk_o
);

    logic en_q;

    // Enable loads while clk_i falls, so it only moves during a low phase
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_i;
        end
    end

    assign clk_o = clk_i & en_q;

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_GATED     = 4,
    parameter int N_FREE      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 100
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               stop_ni,
    input  logic [N_GATED-1:0] gate_mask_i,
    input  logic [N_FREE-1:0]  free_mask_i,
    output logic [N_GATED-1:0] gated_clk_o,
    output logic [N_FREE-1:0]  free_clk_o
);

    logic stop_sync;
    logic run_en;

    clk_stop_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_ni (stop_ni),
        .stop_o (stop_sync)
    );

    clk_stop_fsm #(
        .MIN_RUN (MIN_RUN)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stop_i (stop_sync),
        .run_o  (run_en)
    );

    generate
        for (genvar gi = 0; gi < N_GATED; gi++) begin : g_gated
            clk_gate_cell u_cell (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .en_i   (run_en & gate_mask_i[gi]),
                .clk_o  (gated_clk_o[gi])
            );
        end
        for (genvar fi = 0; fi < N_FREE; fi++) begin : g_free
            clk_gate_cell u_cell (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .en_i   (free_mask_i[fi]),
                .clk_o  (free_clk_o[fi])
            );
        end
    endgenerate

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int N_GATED = 4,
    parameter int N_FREE  = 2,
    parameter int MIN_RUN = 100
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               run_i,
    input logic [N_GATED-1:0] gate_mask_i,
    input logic [N_FREE-1:0]  free_mask_i,
    input logic [N_GATED-1:0] gated_clk_o,
    input logic [N_FREE-1:0]  free_clk_o
);

    localparam int RC_W = $clog2(MIN_RUN + 1);

    logic [RC_W-1:0] run_cnt_q;
    logic            armed_q;

    // Counts consecutive running cycles since the last restart
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt_q <= '0;
            armed_q   <= 1'b0;
        end else begin
            if (!run_i) begin
                run_cnt_q <= '0;
                armed_q   <= 1'b1;
            end else if (run_cnt_q != RC_W'(MIN_RUN)) begin
                run_cnt_q <= run_cnt_q + 1'b1;
            end
        end
    end

    // Sampled just before a rising edge: the low phase must be quiet
    assert_low_phase_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gated_clk_o == '0) && (free_clk_o == '0));

    // Sampled at a falling edge: the high phase reflects the previous mask
    assert_mask_hold_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((gated_clk_o & ~$past(gate_mask_i)) == '0));

    assert_stop_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(run_i)) |-> (gated_clk_o == '0));

    assert_free_runs_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (free_clk_o == $past(free_mask_i)));

    assert_min_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $fell(run_i)) |-> (run_cnt_q >= RC_W'(MIN_RUN)));

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
    .N_GATED (N_GATED),
    .N_FREE  (N_FREE),
    .MIN_RUN (MIN_RUN)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_en),
    .gate_mask_i (gate_mask_i),
    .free_mask_i (free_mask_i),
    .gated_clk_o (gated_clk_o),
    .free_clk_o  (free_clk_o)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;

    localparam int G  = 4;
    localparam int F  = 2;
    localparam int S  = 2;
    localparam int MR = 100;
    localparam int NV = 6;

    // {gate mask, free mask, expected gated, expected free}
    localparam logic [11:0] VEC [NV] = '{
        {4'hF, 2'b11, 4'hF, 2'b11},
        {4'h0, 2'b11, 4'h0, 2'b11},
        {4'h5, 2'b10, 4'h5, 2'b10},
        {4'hA, 2'b01, 4'hA, 2'b01},
        {4'h9, 2'b00, 4'h9, 2'b00},
        {4'h6, 2'b11, 4'h6, 2'b11}
    };

    logic         clk = 1'b0;
    logic         rst_ni;
    logic         stop_ni;
    logic [G-1:0] gm;
    logic [F-1:0] fm;
    logic [G-1:0] gated;
    logic [F-1:0] free;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clk_stop_gate #(
        .N_GATED     (G),
        .N_FREE      (F),
        .SYNC_STAGES (S),
        .MIN_RUN     (MR)
    ) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .stop_ni     (stop_ni),
        .gate_mask_i (gm),
        .free_mask_i (fm),
        .gated_clk_o (gated),
        .free_clk_o  (free)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hi_phase();
        @(posedge clk);
        #5;
    endtask

    task automatic lo_phase();
        @(negedge clk);
        #5;
    endtask

    task automatic drive(input logic s, input logic [G-1:0] g, input logic [F-1:0] f);
        @(posedge clk);
        #2;
        stop_ni = s;
        gm      = g;
        fm      = f;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        rst_ni  = 1'b0;
        stop_ni = 1'b1;
        gm      = 4'hF;
        fm      = 2'b11;

        // R1: quiet in reset
        hi_phase();
        chk("R1 reset gated", 8'(gated), 8'h0);
        chk("R1 reset free", 8'(free), 8'h0);
        @(posedge clk);
        #2 rst_ni = 1'b1;
        hi_phase();
        chk("R1 after reset gated", 8'(gated), 8'hF);
        chk("R1 after reset free", 8'(free), 8'h3);

        // R2/R3/R4: mask table
        for (int v = 0; v < NV; v++) begin
            drive(1'b1, VEC[v][11:8], VEC[v][7:6]);
            hi_phase();
            chk("R2 mask gated", 8'(gated), 8'(VEC[v][5:2]));
            chk("R3 mask free", 8'(free), 8'(VEC[v][1:0]));
            lo_phase();
            chk("R4 low phase", 8'({gated, free}), 8'h0);
        end

        // R5: stop from ST_RUN
        drive(1'b0, 4'hF, 2'b11);
        repeat (S) @(posedge clk);
        #5;
        chk("R5 still running", 8'(gated), 8'hF);
        hi_phase();
        chk("R5 stopped", 8'(gated), 8'h0);
        chk("R3 free during stop", 8'(free), 8'h3);
        lo_phase();
        chk("R4 low while stopped", 8'({gated, free}), 8'h0);

        // R6: mask has no effect while stopped
        drive(1'b0, 4'h7, 2'b01);
        hi_phase();
        chk("R6 mask ignored", 8'(gated), 8'h0);
        chk("R3 free mask in stop", 8'(free), 8'h1);
        drive(1'b0, 4'hB, 2'b11);
        hi_phase();
        chk("R6 stays low", 8'(gated), 8'h0);

        // R8: one-cycle release, window enforced
        drive(1'b1, 4'hB, 2'b11);
        @(posedge clk);
        #2 stop_ni = 1'b0;
        repeat (S - 1) @(posedge clk);
        #5;
        chk("R7 before restart", 8'(gated), 8'h0);
        n = 0;
        for (int p = 0; p < MR + 20; p++) begin
            hi_phase();
            if (gated !== 4'hB) break;
            n++;
        end
        chk("R8 window length", 8'(n), 8'(MR));
        chk("R8 off after window", 8'(gated), 8'h0);
        hi_phase();
        chk("R6 held after window", 8'(gated), 8'h0);

        // R7: sustained release
        drive(1'b1, 4'hB, 2'b11);
        repeat (S) @(posedge clk);
        #5;
        chk("R7 still low", 8'(gated), 8'h0);
        hi_phase();
        chk("R7 full restart", 8'(gated), 8'hB);
        repeat (MR + 10) @(posedge clk);
        #5;
        chk("R8 runs past window", 8'(gated), 8'hB);

        // R5: stop again once in ST_RUN
        drive(1'b0, 4'hB, 2'b11);
        repeat (S) @(posedge clk);
        #5;
        chk("R5 second stop pending", 8'(gated), 8'hB);
        hi_phase();
        chk("R5 second stop", 8'(gated), 8'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule